// File: doc/BRIEF.md
# Page Access-Rights and Fault Checker

This block takes the fields of one translation entry and decides what the current access may do. Its inputs are the lookup result (hit or miss), a 3-bit page type, two privilege bounds, the current privilege level (0 is most privileged, 3 least), the kind of access, and three status bits: dirty, break and reference-trap. From these it produces read, write and execute permission flags and a single prioritised fault code. A physical-mode input bypasses translation completely.

The status bits work in two ways. They raise faults for the access being made. They also remove permission bits from the reported set, so that a later access which relies on those permissions has to be checked again. The block is combinational logic followed by an optional output register stage, which is selected by a parameter. The register stage is on by default and adds one cycle of latency.

Access kind encoding on `kind_i`: 0 probe (a non-architectural lookup), 1 read, 2 write, 3 execute.

Top module: `pgperm_chk`

## Requirements
- R1: When `phys_mode_i` is 1, read, write and execute are all granted and the fault code is 0 (none), whatever the other inputs are.
- R2: When not in physical mode and `hit_i` is 0, all permissions are 0 and the fault code is 1 (miss), for every access kind including probe.
- R3: Read is granted when priv <= read bound. Write is granted when priv <= write bound. Execute is granted only when write bound <= priv <= read bound.
- R4: The page type decodes as follows: 0 gives read only, 1 gives read and write, 2 gives read and execute, 3 gives all three, and 4 to 7 give execute only. Each right is then gated by its privilege condition from R3.
- R5: A probe access on a hit reports the type/privilege permission set with no status-bit stripping, and the fault code is 0.
- R6: When a read, write or execute request is not in the type/privilege set, the fault code is 2 (instruction protection) for execute and 3 (data protection) for read or write. The permissions are reported unstripped and the status bits are ignored.
- R7: A clear dirty bit removes write permission, and a write then gets fault code 6 (dirty). A read with a clear dirty bit gets no fault.
- R8: A set break bit removes write permission, and a write then gets fault code 5 (break).
- R9: A set reference-trap bit removes read and write permission. Read and write accesses then get fault code 4 (reference). Execute accesses keep the execute permission and get no fault.
- R10: When several status faults apply, reference has priority over break, and break has priority over dirty.
- R11: With `REG_OUT`=1, outputs follow the inputs one clock later. An active-low reset clears the outputs to no permissions and fault 0 asynchronously, and the reset is released in step with the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| phys_mode_i | input | 1 | Translation bypass |
| hit_i | input | 1 | Lookup found a valid entry |
| kind_i | input | 2 | Access kind: 0 probe, 1 read, 2 write, 3 execute |
| priv_i | input | PRIV_W | Current privilege level |
| rd_bound_i | input | PRIV_W | Read/execute upper privilege bound |
| wr_bound_i | input | PRIV_W | Write bound and execute lower bound |
| type_i | input | TYPE_W | Page type |
| dirty_i | input | 1 | Page dirty bit |
| break_i | input | 1 | Data break bit |
| reftrap_i | input | 1 | Reference-trap bit |
| perm_r_o | output | 1 | Read permitted |
| perm_w_o | output | 1 | Write permitted |
| perm_x_o | output | 1 | Execute permitted |
| fault_o | output | 3 | Fault code: 0 none, 1 miss, 2 inst prot, 3 data prot, 4 reference, 5 break, 6 dirty |

## Verification
The hardest case to reach is an access that passes the type and privilege check while two or three status bits are active at once. Only then do the stripping and the fault priority interact. The stimulus table therefore pairs write accesses on a fully permissive page with dirty, break and reference-trap combinations, and it crosses an execute access with the reference trap to show that execute keeps its right. Separate vectors set the status bits on requests that fail the protection check, to confirm that those bits are then ignored.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;

  typedef enum logic [1:0] {
    ACC_PROBE = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_EXEC  = 2'd3
  } acc_kind_e;

  localparam int FAULT_W = 3;

  typedef enum logic [FAULT_W-1:0] {
    FLT_NONE  = 3'd0,
    FLT_MISS  = 3'd1,
    FLT_IPROT = 3'd2,
    FLT_DPROT = 3'd3,
    FLT_REF   = 3'd4,
    FLT_BRK   = 3'd5,
    FLT_DIRTY = 3'd6
  } fault_e;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } perm_t;

  localparam perm_t PERM_NONE = '{r: 1'b0, w: 1'b0, x: 1'b0};
  localparam perm_t PERM_ALL  = '{r: 1'b1, w: 1'b1, x: 1'b1};

endpackage

// File: rtl/pgperm_rights.sv
// Type/privilege permission set, before any status-bit stripping.
module pgperm_rights
  import pgperm_pkg::*;
#(
  parameter int PRIV_W = 2,
  parameter int TYPE_W = 3
) (
  input  logic [PRIV_W-1:0] priv_i,
  input  logic [PRIV_W-1:0] rd_bound_i,
  input  logic [PRIV_W-1:0] wr_bound_i,
  input  logic [TYPE_W-1:0] type_i,
  output perm_t             base_o
);

  localparam logic [TYPE_W-1:0] TYPE_LAST_MIXED = TYPE_W'(3);

  logic rd_ok;
  logic wr_ok;
  logic ex_ok;
  logic exec_only;

  always_comb begin
    rd_ok     = (priv_i <= rd_bound_i);
    wr_ok     = (priv_i <= wr_bound_i);
    ex_ok     = (wr_bound_i <= priv_i) && rd_ok;
    exec_only = (type_i > TYPE_LAST_MIXED);

    base_o = PERM_NONE;
    if (exec_only) begin
      base_o.x = ex_ok;
    end else begin
      base_o.r = rd_ok;
      case (type_i[1:0])
        2'd1:    base_o.w = wr_ok;
        2'd2:    base_o.x = ex_ok;
        2'd3: begin
          base_o.w = wr_ok;
          base_o.x = ex_ok;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pgperm_status.sv
// Status-bit stripping and status fault selection (reference > break > dirty).
module pgperm_status
  import pgperm_pkg::*;
(
  input  perm_t     base_i,
  input  acc_kind_e kind_i,
  input  logic      dirty_i,
  input  logic      break_i,
  input  logic      reftrap_i,
  output perm_t     perm_o,
  output fault_e    fault_o
);

  logic is_wr;
  logic is_ex;

  always_comb begin
    is_wr = (kind_i == ACC_WRITE);
    is_ex = (kind_i == ACC_EXEC);

    perm_o = base_i;
    if (!dirty_i || break_i) begin
      perm_o.w = 1'b0;
    end
    if (reftrap_i) begin
      perm_o.r = 1'b0;
      perm_o.w = 1'b0;
    end

    if (reftrap_i && !is_ex) begin
      fault_o = FLT_REF;
    end else if (break_i && is_wr) begin
      fault_o = FLT_BRK;
    end else if (!dirty_i && is_wr) begin
      fault_o = FLT_DIRTY;
    end else begin
      fault_o = FLT_NONE;
    end
  end

endmodule

// File: rtl/pgperm_chk.sv
module pgperm_chk
  import pgperm_pkg::*;
#(
  parameter int PRIV_W  = 2,
  parameter int TYPE_W  = 3,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phys_mode_i,
  input  logic              hit_i,
  input  logic [1:0]        kind_i,
  input  logic [PRIV_W-1:0] priv_i,
  input  logic [PRIV_W-1:0] rd_bound_i,
  input  logic [PRIV_W-1:0] wr_bound_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic              dirty_i,
  input  logic              break_i,
  input  logic              reftrap_i,
  output logic              perm_r_o,
  output logic              perm_w_o,
  output logic              perm_x_o,
  output logic [2:0]        fault_o
);

  acc_kind_e kind;
  perm_t     base_perm;
  perm_t     strip_perm;
  fault_e    stat_flt;
  perm_t     nxt_perm;
  fault_e    nxt_flt;
  perm_t     out_perm;
  fault_e    out_flt;
  logic      req_ok;

  assign kind = acc_kind_e'(kind_i);

  pgperm_rights #(
    .PRIV_W(PRIV_W),
    .TYPE_W(TYPE_W)
  ) u_rights (
    .priv_i    (priv_i),
    .rd_bound_i(rd_bound_i),
    .wr_bound_i(wr_bound_i),
    .type_i    (type_i),
    .base_o    (base_perm)
  );

  pgperm_status u_status (
    .base_i   (base_perm),
    .kind_i   (kind),
    .dirty_i  (dirty_i),
    .break_i  (break_i),
    .reftrap_i(reftrap_i),
    .perm_o   (strip_perm),
    .fault_o  (stat_flt)
  );

  // Next-state selection: physical > miss > probe > protection > status.
  always_comb begin
    case (kind)
      ACC_READ:  req_ok = base_perm.r;
      ACC_WRITE: req_ok = base_perm.w;
      ACC_EXEC:  req_ok = base_perm.x;
      default:   req_ok = 1'b1;
    endcase

    if (phys_mode_i) begin
      nxt_perm = PERM_ALL;
      nxt_flt  = FLT_NONE;
    end else if (!hit_i) begin
      nxt_perm = PERM_NONE;
      nxt_flt  = FLT_MISS;
    end else if (kind == ACC_PROBE) begin
      nxt_perm = base_perm;
      nxt_flt  = FLT_NONE;
    end else if (!req_ok) begin
      nxt_perm = base_perm;
      nxt_flt  = (kind == ACC_EXEC) ? FLT_IPROT : FLT_DPROT;
    end else begin
      nxt_perm = strip_perm;
      nxt_flt  = stat_flt;
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      logic [1:0] rst_sync_q;
      logic       rst_int_n;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rst_sync_q <= 2'b00;
        end else begin
          rst_sync_q <= {rst_sync_q[0], 1'b1};
        end
      end

      assign rst_int_n = rst_sync_q[1];

      always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n) begin
          out_perm <= PERM_NONE;
          out_flt  <= FLT_NONE;
        end else begin
          out_perm <= nxt_perm;
          out_flt  <= nxt_flt;
        end
      end
    end else begin : g_comb
      assign out_perm = nxt_perm;
      assign out_flt  = nxt_flt;
    end
  endgenerate

  assign perm_r_o = out_perm.r;
  assign perm_w_o = out_perm.w;
  assign perm_x_o = out_perm.x;
  assign fault_o  = out_flt;

endmodule

// File: rtl/pgperm_chk_sva.sv
module pgperm_chk_sva
  import pgperm_pkg::*;
#(
  parameter int PRIV_W  = 2,
  parameter int TYPE_W  = 3,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              phys_mode_i,
  input logic              hit_i,
  input logic [1:0]        kind_i,
  input logic [PRIV_W-1:0] priv_i,
  input logic [PRIV_W-1:0] rd_bound_i,
  input logic [PRIV_W-1:0] wr_bound_i,
  input logic [TYPE_W-1:0] type_i,
  input logic              dirty_i,
  input logic              break_i,
  input logic              reftrap_i,
  input logic              perm_r_o,
  input logic              perm_w_o,
  input logic              perm_x_o,
  input logic [2:0]        fault_o
);

  logic              c_phys;
  logic              c_hit;
  logic [1:0]        c_kind;
  logic [PRIV_W-1:0] c_priv;
  logic [PRIV_W-1:0] c_rb;
  logic [PRIV_W-1:0] c_wb;
  logic              c_dirty;
  logic              c_brk;
  logic              c_ref;
  logic [1:0]        on_cnt;
  logic              chk_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_cnt <= 2'd0;
    end else if (on_cnt != 2'd3) begin
      on_cnt <= on_cnt + 2'd1;
    end
  end
  assign chk_on = (on_cnt == 2'd3);

  generate
    if (REG_OUT) begin : g_align
      always_ff @(posedge clk) begin
        c_phys  <= phys_mode_i;
        c_hit   <= hit_i;
        c_kind  <= kind_i;
        c_priv  <= priv_i;
        c_rb    <= rd_bound_i;
        c_wb    <= wr_bound_i;
        c_dirty <= dirty_i;
        c_brk   <= break_i;
        c_ref   <= reftrap_i;
      end
    end else begin : g_direct
      assign c_phys  = phys_mode_i;
      assign c_hit   = hit_i;
      assign c_kind  = kind_i;
      assign c_priv  = priv_i;
      assign c_rb    = rd_bound_i;
      assign c_wb    = wr_bound_i;
      assign c_dirty = dirty_i;
      assign c_brk   = break_i;
      assign c_ref   = reftrap_i;
    end
  endgenerate

  logic unused_type;
  assign unused_type = ^type_i;

  assert_phys_grant_R1: assert property (@(posedge clk) disable iff (!rst_n || !chk_on)
    c_phys |-> (perm_r_o && perm_w_o && perm_x_o && fault_o == 3'd0));

  assert_miss_clear_R2: assert property (@(posedge clk) disable iff (!rst_n || !chk_on)
    (!c_phys && !c_hit) |-> (fault_o == 3'd1 && !perm_r_o && !perm_w_o && !perm_x_o));

  assert_exec_window_R3: assert property (@(posedge clk) disable iff (!rst_n || !chk_on)
    (!c_phys && perm_x_o) |-> (c_wb <= c_priv && c_priv <= c_rb));

  assert_probe_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n || !chk_on)
    (!c_phys && c_hit && c_kind == 2'd0) |-> (fault_o == 3'd0));

  assert_iprot_exec_R6: assert property (@(posedge clk) disable iff (!rst_n || !chk_on)
    (fault_o == 3'd2) |-> (c_kind == 2'd3));

  assert_dirty_write_R7: assert property (@(posedge clk) disable iff (!rst_n || !chk_on)
    (fault_o == 3'd6) |-> (!c_dirty && c_kind == 2'd2 && !perm_w_o));

  assert_ref_strip_R9: assert property (@(posedge clk) disable iff (!rst_n || !chk_on)
    (fault_o == 3'd4) |-> (!perm_r_o && !perm_w_o && c_kind != 2'd3 && c_ref));

  assert_break_prio_R10: assert property (@(posedge clk) disable iff (!rst_n || !chk_on)
    (fault_o == 3'd5) |-> (c_brk && !c_ref));

  assert_code_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o != 3'd7));

endmodule

bind pgperm_chk pgperm_chk_sva #(
  .PRIV_W (PRIV_W),
  .TYPE_W (TYPE_W),
  .REG_OUT(REG_OUT)
) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .phys_mode_i(phys_mode_i),
  .hit_i      (hit_i),
  .kind_i     (kind_i),
  .priv_i     (priv_i),
  .rd_bound_i (rd_bound_i),
  .wr_bound_i (wr_bound_i),
  .type_i     (type_i),
  .dirty_i    (dirty_i),
  .break_i    (break_i),
  .reftrap_i  (reftrap_i),
  .perm_r_o   (perm_r_o),
  .perm_w_o   (perm_w_o),
  .perm_x_o   (perm_x_o),
  .fault_o    (fault_o)
);

// File: tb/test_pgperm_chk.sv
`timescale 1ns/1ps
module test_pgperm_chk;

  logic       clk;
  logic       rst_n;
  logic       phys_mode_i;
  logic       hit_i;
  logic [1:0] kind_i;
  logic [1:0] priv_i;
  logic [1:0] rd_bound_i;
  logic [1:0] wr_bound_i;
  logic [2:0] type_i;
  logic       dirty_i;
  logic       break_i;
  logic       reftrap_i;
  logic       perm_r_o;
  logic       perm_w_o;
  logic       perm_x_o;
  logic [2:0] fault_o;

  int n_checks;
  int n_fails;
  bit done;

  pgperm_chk i_pgperm_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .phys_mode_i(phys_mode_i),
    .hit_i      (hit_i),
    .kind_i     (kind_i),
    .priv_i     (priv_i),
    .rd_bound_i (rd_bound_i),
    .wr_bound_i (wr_bound_i),
    .type_i     (type_i),
    .dirty_i    (dirty_i),
    .break_i    (break_i),
    .reftrap_i  (reftrap_i),
    .perm_r_o   (perm_r_o),
    .perm_w_o   (perm_w_o),
    .perm_x_o   (perm_x_o),
    .fault_o    (fault_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // [21] phys [20] hit [19:18] kind [17:16] priv [15:14] rd bound [13:12] wr bound
  // [11:9] type [8] dirty [7] break [6] reftrap | expected [5] r [4] w [3] x [2:0] fault
  localparam int NV = 22;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1,1'b0,2'd2,2'd3,2'd0,2'd0,3'd0,1'b0,1'b1,1'b1, 1'b1,1'b1,1'b1,3'd0},
    {1'b0,1'b0,2'd1,2'd0,2'd3,2'd3,3'd3,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,3'd1},
    {1'b0,1'b0,2'd0,2'd0,2'd3,2'd3,3'd3,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,3'd1},
    {1'b0,1'b1,2'd1,2'd1,2'd2,2'd0,3'd3,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b1,3'd0},
    {1'b0,1'b1,2'd2,2'd1,2'd2,2'd0,3'd3,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b1,3'd3},
    {1'b0,1'b1,2'd3,2'd3,2'd2,2'd0,3'd3,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,3'd2},
    {1'b0,1'b1,2'd1,2'd0,2'd3,2'd3,3'd0,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0,3'd0},
    {1'b0,1'b1,2'd2,2'd0,2'd3,2'd3,3'd1,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0,3'd0},
    {1'b0,1'b1,2'd3,2'd0,2'd3,2'd0,3'd2,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b1,3'd0},
    {1'b0,1'b1,2'd3,2'd0,2'd3,2'd0,3'd5,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b1,3'd0},
    {1'b0,1'b1,2'd1,2'd0,2'd3,2'd0,3'd5,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b1,3'd3},
    {1'b0,1'b1,2'd2,2'd0,2'd3,2'd3,3'd3,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,3'd6},
    {1'b0,1'b1,2'd1,2'd0,2'd3,2'd3,3'd3,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,3'd0},
    {1'b0,1'b1,2'd2,2'd0,2'd3,2'd3,3'd3,1'b1,1'b1,1'b0, 1'b1,1'b0,1'b0,3'd5},
    {1'b0,1'b1,2'd2,2'd0,2'd3,2'd3,3'd3,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b0,3'd5},
    {1'b0,1'b1,2'd2,2'd0,2'd3,2'd3,3'd3,1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0,3'd4},
    {1'b0,1'b1,2'd3,2'd0,2'd3,2'd0,3'd3,1'b1,1'b0,1'b1, 1'b0,1'b0,1'b1,3'd0},
    {1'b0,1'b1,2'd1,2'd0,2'd3,2'd0,3'd3,1'b1,1'b0,1'b1, 1'b0,1'b0,1'b1,3'd4},
    {1'b0,1'b1,2'd0,2'd0,2'd3,2'd0,3'd3,1'b0,1'b1,1'b1, 1'b1,1'b1,1'b1,3'd0},
    {1'b0,1'b1,2'd0,2'd3,2'd0,2'd0,3'd0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,3'd0},
    {1'b0,1'b1,2'd3,2'd0,2'd3,2'd0,3'd3,1'b0,1'b1,1'b1, 1'b0,1'b0,1'b1,3'd0},
    {1'b0,1'b1,2'd2,2'd0,2'd3,2'd3,3'd0,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b0,3'd3}
  };

  function automatic string vtag(int i);
    case (i)
      0:       return "R1 physical bypass";
      1, 2:    return "R2 miss";
      3:       return "R3 privilege window";
      4:       return "R6 R3 write above bound";
      5:       return "R6 R3 exec outside window";
      6, 7, 8: return "R4 type decode";
      9:       return "R4 execute-only type";
      10:      return "R6 R4 read on execute-only";
      11:      return "R7 dirty write";
      12:      return "R7 dirty read";
      13:      return "R8 break write";
      14:      return "R10 break over dirty";
      15:      return "R10 R9 reference over break";
      16, 20:  return "R9 execute keeps right";
      17:      return "R9 reference read";
      18, 19:  return "R5 probe";
      default: return "R6 status ignored on protection fault";
    endcase
  endfunction

  task automatic drive(input logic [21:0] v);
    phys_mode_i = v[21];
    hit_i       = v[20];
    kind_i      = v[19:18];
    priv_i      = v[17:16];
    rd_bound_i  = v[15:14];
    wr_bound_i  = v[13:12];
    type_i      = v[11:9];
    dirty_i     = v[8];
    break_i     = v[7];
    reftrap_i   = v[6];
  endtask

  task automatic check(input string tag, input logic [5:0] exp);
    n_checks++;
    if ({perm_r_o, perm_w_o, perm_x_o, fault_o} !== exp) begin
      n_fails++;
      $display("FAIL %s: got r%b w%b x%b fault %0d, expected r%b w%b x%b fault %0d",
               tag, perm_r_o, perm_w_o, perm_x_o, fault_o,
               exp[5], exp[4], exp[3], exp[2:0]);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    n_checks = 0;
    n_fails  = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    drive({1'b1, 1'b1, 20'd0});
    repeat (3) @(negedge clk);
    // R11: reset state while reset is held, even with physical mode requested
    check("R11 reset state", 6'b000_000);

    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Main table: drive at a falling edge, sample one rising edge later
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(posedge clk);
      @(negedge clk);
      check($sformatf("%s (vector %0d)", vtag(i), i), VEC[i][5:0]);
    end

    // R11 latency: a miss, then physical mode; old value must hold until the edge
    drive({1'b0, 1'b0, 20'd0});
    @(posedge clk);
    @(negedge clk);
    check("R11 miss settled", 6'b000_001);
    drive({1'b1, 1'b0, 20'd0});
    #2;
    check("R11 output holds before edge", 6'b000_001);
    @(posedge clk);
    @(negedge clk);
    check("R11 output updates after one edge", 6'b111_000);

    // R11: asynchronous clear in mid-cycle
    #3;
    rst_n = 1'b0;
    #2;
    check("R11 asynchronous clear", 6'b000_000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 recovery after reset", 6'b111_000);

    finish_run();
  end

endmodule